// File: doc/BRIEF.md
# Banked Data-Memory Address Unit

This block is the byte-wide data store of a small accumulator machine, together with the address logic in front of it. The data space is a single 9-bit range, 0x000 to 0x1FF, organized as four 128-byte pages. An instruction can name only a 7-bit file field. For a direct access, two page-select bits held in a status register supply the upper two address bits.

Naming file field 0x00 makes the access indirect. In that case an 8-bit pointer register supplies address bits 7..0 and a separate status bit supplies bit 8. The page-select bits play no part in an indirect access, so one pointer value reaches across two pages without any page switch.

The status register, the pointer register and the indirect alias occupy the same offsets in every page. Single bits of the status register can be set or cleared through a dedicated port. Reads are combinational from the formed address, and writes take effect on the rising clock edge.

Top module: `banked_dmem`

## Requirements
- R1: While reset is asserted (rst_n low), the status and pointer registers clear to 0x00. After reset, a read of field 0x03 and a read of field 0x04 both return 0x00.
- R2: When acc_addr is not 0x00, the access is direct and eff_addr = {status[6], status[5], acc_addr}. Status bit 6 is the upper page bit and bit 5 is the lower page bit.
- R3: When acc_addr is 0x00, the access is indirect and eff_addr = {status[7], pointer}. Status bits 6 and 5 are ignored. For example, pointer 0xA5 with status bit 7 set gives 0x1A5.
- R4: The status register at offset 0x03 and the pointer register at offset 0x04 read and write identically in all four pages, including a page that has no implemented storage.
- R5: With bit_en high, status bit bit_idx takes the value bit_val at the clock edge and the other status bits keep their values. When a byte write to the status register happens in the same cycle, it is applied first and the bit operation then overrides the selected bit.
- R6: An indirect access whose formed address has offset 0x00 reads 0x00. A write through such an access changes neither status, pointer nor any memory location.
- R7: A location is implemented only if its page is enabled in PAGE_EN and its offset is at least GPR_BASE. By default pages 0 to 2 are enabled, page 3 is not, and GPR_BASE is 0x20. Reads of unimplemented locations return 0x00 and writes to them are discarded.
- R8: rd_data follows acc_addr and the register state without a clock. A write becomes visible only after the rising clock edge on which wr_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Active-low reset of status and pointer |
| acc_addr | input | 7 | File field from the instruction |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_en | input | 1 | Status single-bit update strobe |
| bit_idx | input | 3 | Status bit to update |
| bit_val | input | 1 | Value for the selected status bit |
| rd_data | output | 8 | Combinational read data |
| eff_addr | output | 9 | Formed 9-bit data address |

## Verification
A wrong page bit in the status register shows up on eff_addr in the same cycle as the next direct access, and rd_data then returns another page's byte. A corrupted pointer, or a corrupted indirect page bit, shows up immediately on any access through field 0x00. A write that lands on the wrong page stays hidden until that location is read back. For this reason the bench reads each page after writing all of them, and reads the aliasing neighbour of every discarded write.

// File: rtl/banked_dmem.sv
module banked_dmem #(
  parameter int          DIR_W     = 7,
  parameter int          DATA_W    = 8,
  parameter logic [3:0]  PAGE_EN   = 4'b0111,
  parameter logic [6:0]  GPR_BASE  = 7'h20,
  parameter logic [6:0]  ALIAS_OFS = 7'h00,
  parameter logic [6:0]  STAT_OFS  = 7'h03,
  parameter logic [6:0]  PTR_OFS   = 7'h04,
  parameter int          IRP_BIT   = 7,
  parameter int          RP1_BIT   = 6,
  parameter int          RP0_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIR_W-1:0]  acc_addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bit_en,
  input  logic [2:0]        bit_idx,
  input  logic              bit_val,
  output logic [DATA_W-1:0] rd_data,
  output logic [DIR_W+1:0]  eff_addr
);
  localparam int AW    = DIR_W + 2;
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] stat_q, ptr_q, stat_nxt;
  logic [DATA_W-1:0] ram [DEPTH];

  wire indirect = (acc_addr == ALIAS_OFS);

  assign eff_addr = indirect ? {stat_q[IRP_BIT], ptr_q[DIR_W:0]}
                             : {stat_q[RP1_BIT], stat_q[RP0_BIT], acc_addr};

  wire [DIR_W-1:0] ofs  = eff_addr[DIR_W-1:0];
  wire [1:0]       page = eff_addr[AW-1:DIR_W];

  wire hit_stat = (ofs == STAT_OFS);
  wire hit_ptr  = (ofs == PTR_OFS);
  wire hit_ram  = PAGE_EN[page] && (ofs >= GPR_BASE);

  assign rd_data = hit_stat ? stat_q :
                   hit_ptr  ? ptr_q  :
                   hit_ram  ? ram[eff_addr] : '0;

  always_comb begin
    stat_nxt = (wr_en && hit_stat) ? wr_data : stat_q;
    if (bit_en) stat_nxt[bit_idx] = bit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ptr_q  <= '0;
    end else begin
      stat_q <= stat_nxt;
      if (wr_en && hit_ptr) ptr_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && hit_ram) ram[eff_addr] <= wr_data;
  end
endmodule

// File: rtl/banked_dmem_chk.sv
module banked_dmem_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] acc_addr,
  input logic       wr_en,
  input logic       bit_en,
  input logic [2:0] bit_idx,
  input logic       bit_val,
  input logic [7:0] rd_data,
  input logic [8:0] eff_addr,
  input logic [7:0] stat_q,
  input logic [7:0] ptr_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (stat_q == 8'h00 && ptr_q == 8'h00));

  // R2
  direct_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr != 7'h00) |-> (eff_addr[8:7] == stat_q[6:5] && eff_addr[6:0] == acc_addr));

  // R3
  indirect_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 7'h00) |-> (eff_addr == {stat_q[7], ptr_q}));

  // R5
  bit_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (stat_q[$past(bit_idx)] == $past(bit_val)));

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !bit_en) |=> $stable(stat_q));

  // R6
  alias_loop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_addr == 7'h00 && ptr_q[6:0] == 7'h00) |-> (rd_data == 8'h00));

  // R8
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ptr_q));
endmodule

bind banked_dmem banked_dmem_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .wr_en(wr_en),
  .bit_en(bit_en), .bit_idx(bit_idx), .bit_val(bit_val),
  .rd_data(rd_data), .eff_addr(eff_addr), .stat_q(stat_q), .ptr_q(ptr_q)
);

// File: tb/banked_dmem_test.sv
`timescale 1ns/1ps
module banked_dmem_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [6:0] acc_addr = 0;
  logic       wr_en = 0;
  logic [7:0] wr_data = 0;
  logic       bit_en = 0;
  logic [2:0] bit_idx = 0;
  logic       bit_val = 0;
  logic [7:0] rd_data;
  logic [8:0] eff_addr;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  banked_dmem uut (.*);

  task automatic check(string req, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk); acc_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d, output logic [8:0] e);
    @(negedge clk); acc_addr = a; #1; d = rd_data; e = eff_addr;
  endtask

  task automatic bitop(input logic [2:0] i, input logic v);
    @(negedge clk); bit_idx = i; bit_val = v; bit_en = 1;
    @(negedge clk); bit_en = 0;
  endtask

  task automatic t_reset;
    logic [7:0] d; logic [8:0] e;
    rd(7'h03, d, e); check("R1 status", {1'b0, d}, 9'h000);
    rd(7'h04, d, e); check("R1 pointer", {1'b0, d}, 9'h000);
  endtask

  task automatic t_direct;
    logic [7:0] d; logic [8:0] e;
    logic [6:0] f [3] = '{7'h05, 7'h21, 7'h7F};
    for (int p = 0; p < 4; p++) begin
      wr(7'h03, {1'b0, p[1:0], 5'b0});
      for (int k = 0; k < 3; k++) begin
        rd(f[k], d, e); check("R2 eff_addr", e, {p[1:0], f[k]});
      end
      wr(7'h21, 8'hA0 + p[7:0]);
    end
    for (int p = 0; p < 4; p++) begin
      wr(7'h03, {1'b0, p[1:0], 5'b0});
      rd(7'h21, d, e);
      check("R2 page data", {1'b0, d}, (p < 3) ? {1'b0, 8'hA0 + p[7:0]} : 9'h000);
    end
  endtask

  task automatic t_timing;
    wr(7'h03, 8'h00);
    wr(7'h30, 8'h11);
    @(negedge clk); acc_addr = 7'h30; wr_data = 8'h99; wr_en = 1; #1;
    check("R8 before edge", {1'b0, rd_data}, 9'h011);
    @(posedge clk); #1;
    check("R8 after edge", {1'b0, rd_data}, 9'h099);
    @(negedge clk); wr_en = 0; acc_addr = 7'h31; #1;
    acc_addr = 7'h30; #1;
    check("R8 comb read", {1'b0, rd_data}, 9'h099);
  endtask

  task automatic t_indirect;
    logic [7:0] d; logic [8:0] e;
    wr(7'h04, 8'hA5);
    for (int s = 0; s < 8; s++) begin
      wr(7'h03, {s[2:0], 5'b0});
      rd(7'h00, d, e); check("R3 eff_addr", e, {s[2], 8'hA5});
    end
    wr(7'h03, 8'h60);
    wr(7'h00, 8'h5A);
    wr(7'h03, 8'h20);
    rd(7'h25, d, e); check("R3 write via pointer", {1'b0, d}, 9'h05A);
    wr(7'h04, 8'h40);
    wr(7'h03, 8'h80);
    wr(7'h00, 8'hC3);
    wr(7'h03, 8'h40);
    rd(7'h40, d, e); check("R3 high page via pointer", {1'b0, d}, 9'h0C3);
  endtask

  task automatic t_mirror;
    logic [7:0] d; logic [8:0] e;
    for (int p = 0; p < 4; p++) begin
      wr(7'h03, {1'b0, p[1:0], 5'h0A});
      rd(7'h03, d, e); check("R4 status mirror", {1'b0, d}, {1'b0, 1'b0, p[1:0], 5'h0A});
      wr(7'h04, 8'h30 + p[7:0]);
      rd(7'h04, d, e); check("R4 pointer mirror", {1'b0, d}, {1'b0, 8'h30 + p[7:0]});
    end
  endtask

  task automatic t_bitop;
    logic [7:0] d; logic [8:0] e;
    wr(7'h03, 8'h00);
    bitop(3'd5, 1'b1); rd(7'h03, d, e); check("R5 set bit5", {1'b0, d}, 9'h020);
    bitop(3'd7, 1'b1); rd(7'h03, d, e); check("R5 set bit7", {1'b0, d}, 9'h0A0);
    bitop(3'd6, 1'b1); rd(7'h03, d, e); check("R5 set bit6", {1'b0, d}, 9'h0E0);
    bitop(3'd5, 1'b0); rd(7'h03, d, e); check("R5 clear bit5", {1'b0, d}, 9'h0C0);
    rd(7'h10, d, e); check("R5 page after bit ops", e, 9'h110);
    @(negedge clk); acc_addr = 7'h03; wr_data = 8'h00; wr_en = 1;
    bit_idx = 3'd6; bit_val = 1'b1; bit_en = 1;
    @(negedge clk); wr_en = 0; bit_en = 0;
    rd(7'h03, d, e); check("R5 bit op over byte write", {1'b0, d}, 9'h040);
  endtask

  task automatic t_loop;
    logic [7:0] d; logic [8:0] e;
    wr(7'h04, 8'h80);
    wr(7'h03, 8'h80);
    rd(7'h00, d, e); check("R6 loop read", {1'b0, d}, 9'h000);
    wr(7'h00, 8'h77);
    rd(7'h03, d, e); check("R6 status untouched", {1'b0, d}, 9'h080);
    rd(7'h04, d, e); check("R6 pointer untouched", {1'b0, d}, 9'h080);
    rd(7'h00, d, e); check("R6 loop read after write", {1'b0, d}, 9'h000);
  endtask

  task automatic t_unimpl;
    logic [7:0] d; logic [8:0] e;
    wr(7'h03, 8'h20);
    wr(7'h40, 8'h12);
    wr(7'h03, 8'h60);
    wr(7'h40, 8'hEE);
    rd(7'h40, d, e); check("R7 page3 read", {1'b0, d}, 9'h000);
    wr(7'h03, 8'h20);
    rd(7'h40, d, e); check("R7 no alias write", {1'b0, d}, 9'h012);
    wr(7'h03, 8'h00);
    wr(7'h10, 8'h55);
    rd(7'h10, d, e); check("R7 low offset read", {1'b0, d}, 9'h000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_direct();
    t_timing();
    t_indirect();
    t_mirror();
    t_bitop();
    t_loop();
    t_unimpl();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule